// File: doc/BRIEF.md
# Decoded Byte-Wide Memory Subsystem

This block places four byte-wide devices behind one 8-bit address bus that spans 256 locations: a 64-byte scratch RAM, a 32-byte auxiliary RAM, a bank of eight output port registers and a 32-byte constant ROM. A full address decoder compares every address bit above each device's window, so each location maps to at most one device. Some addresses map to no device.

The requesting side has an address, a write-data byte, a read-data byte and two strobes. The read and write paths are separate, so no shared tri-state bus is needed. Each device gets its own select, write-enable and output-enable. The block derives them from the decoder and the strobes. A device accepts data only with select=1, write-enable=1 and output-enable=0. It drives read data only with select=1, write-enable=0 and output-enable=1.

Writes land on the rising clock edge. Reads are combinational and valid in the same cycle as the read strobe. The eight port registers are also presented as a flat output vector. The ROM image is a parameter.

Top module: `mmap_subsys`

## Requirements
- R1: The address decoder selects the devices as follows:
  - Scratch RAM for 0x00–0x3F.
  - Auxiliary RAM for 0x40–0x5F.
  - Port bank for 0xD0–0xD7.
  - ROM for 0xE0–0xFF.
  - Never more than one device at once.
- R2: A write with `wr_en`=1 and `rd_en`=0 stores `wdata` at the clock edge. A later read of the same RAM address returns that byte on `rdata` in the same cycle as `rd_en`.
- R3: For addresses 0x60–0xCF and 0xD8–0xDF, a read returns 0x00 and a write changes no stored byte.
- R4: A ROM read returns byte i of `ROM_INIT`, bits [8i+7:8i], where i = address − 0xE0. A write into the ROM window leaves the ROM contents unchanged.
- R5: A write to 0xD0+k sets port k. Port k appears on `io_ports[8k+7:8k]` from the next cycle and reads back at that address. Ports that are not written hold their values.
- R6: With `wr_en`=1 and `rd_en`=1 together, nothing is written and `rdata` is 0x00. `req_err` is 1 for exactly the following cycle.
- R7: With `rd_en`=0, `rdata` is 0x00 whatever the address.
- R8: After reset, both RAMs and all ports hold 0x00 and `req_err` is 0. Reset is synchronous and active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Bus address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data (combinational) |
| io_ports | output | 64 | Eight port registers, port k in bits [8k+7:8k] |
| req_err | output | 1 | One-cycle flag after a request with both strobes set |

## Verification
The bench builds the block with the default memory map and the default computed ROM image. It can therefore sweep every one of the 256 addresses, including the unmapped gaps and each window edge (0x3F/0x40, 0x5F/0x60, 0xCF/0xD0, 0xD7/0xD8, 0xDF/0xE0). The ROM is small enough that a ROM-window write can be checked by reading back the exact byte it targeted. All eight ports can be written and observed both on the port vector and through reads.

// File: rtl/mm_pkg.sv
package mm_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int N_DEV  = 4;

  // Window base and log2 size per device; index order matches dev_e
  localparam int RAM0_BASE = 0;
  localparam int RAM0_AW   = 6;
  localparam int RAM1_BASE = 64;
  localparam int RAM1_AW   = 5;
  localparam int IO_BASE   = 208;
  localparam int IO_AW     = 3;
  localparam int ROM_BASE  = 224;
  localparam int ROM_AW    = 5;

  localparam int ROM_WORDS = 1 << ROM_AW;
  localparam int IO_WORDS  = 1 << IO_AW;

  typedef enum logic [1:0] {DEV_RAM0, DEV_RAM1, DEV_IO, DEV_ROM} dev_e;

  // Full decode: all bits above the window must equal the base
  function automatic logic in_window(logic [ADDR_W-1:0] a, int base, int aw);
    return (int'(a) >> aw) == (base >> aw);
  endfunction

  // Default ROM image: byte i = (29*i + 60) mod 256
  function automatic logic [ROM_WORDS*DATA_W-1:0] rom_default();
    logic [ROM_WORDS*DATA_W-1:0] img;
    img = '0;
    for (int i = 0; i < ROM_WORDS; i++) begin
      img[i*DATA_W +: DATA_W] = DATA_W'((29 * i + 60) % 256);
    end
    return img;
  endfunction
endpackage

// File: rtl/mm_decode.sv
module mm_decode
  import mm_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic [N_DEV-1:0]  sel
);
  localparam int BASES [N_DEV] = '{RAM0_BASE, RAM1_BASE, IO_BASE, ROM_BASE};
  localparam int SIZES [N_DEV] = '{RAM0_AW, RAM1_AW, IO_AW, ROM_AW};

  for (genvar i = 0; i < N_DEV; i++) begin : g_win
    assign sel[i] = in_window(addr, BASES[i], SIZES[i]);
  end
endmodule

// File: rtl/mm_ram.sv
module mm_ram #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          we,
  input  logic          oe,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] dout
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];
  logic          wr_fire;
  logic          rd_fire;

  assign wr_fire = cs & we & ~oe;
  assign rd_fire = cs & oe & ~we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (wr_fire) begin
      mem[addr] <= wdata;
    end
  end

  assign dout = rd_fire ? mem[addr] : '0;

  // R2: a write lands in the addressed word one edge later
  p_ram_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> mem[$past(addr)] == $past(wdata));
endmodule

// File: rtl/mm_ioport.sv
module mm_ioport #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs,
  input  logic                    we,
  input  logic                    oe,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           dout,
  output logic [(1<<AW)*DW-1:0]   port_o
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] regs [WORDS];
  logic          wr_fire;
  logic          rd_fire;

  assign wr_fire = cs & we & ~oe;
  assign rd_fire = cs & oe & ~we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) regs[i] <= '0;
    end else if (wr_fire) begin
      regs[addr] <= wdata;
    end
  end

  for (genvar k = 0; k < WORDS; k++) begin : g_port
    assign port_o[k*DW +: DW] = regs[k];
  end

  assign dout = rd_fire ? regs[addr] : '0;

  // R5: ports only move when this bank is written
  p_io_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(port_o));
endmodule

// File: rtl/mm_rom.sv
module mm_rom #(
  parameter int AW = 5,
  parameter int DW = 8,
  parameter logic [(1<<AW)*DW-1:0] INIT = '0
) (
  input  logic          cs,
  input  logic          we,
  input  logic          oe,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] dout
);
  logic rd_fire;
  assign rd_fire = cs & oe & ~we;
  assign dout    = rd_fire ? INIT[addr*DW +: DW] : '0;
endmodule

// File: rtl/mmap_subsys.sv
module mmap_subsys
  import mm_pkg::*;
#(
  parameter logic [ROM_WORDS*DATA_W-1:0] ROM_INIT = mm_pkg::rom_default()
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       wr_en,
  input  logic                       rd_en,
  output logic [DATA_W-1:0]          rdata,
  output logic [IO_WORDS*DATA_W-1:0] io_ports,
  output logic                       req_err
);
  logic [N_DEV-1:0]  sel;
  logic              bus_we;
  logic              bus_oe;
  logic              illegal;
  logic [DATA_W-1:0] dout_ram0, dout_ram1, dout_io, dout_rom;
  logic              err_q;

  mm_decode u_dec (.addr(addr), .sel(sel));

  // Conflicting strobes become a no-op: neither enable asserted
  assign illegal = wr_en & rd_en;
  assign bus_we  = wr_en & ~rd_en;
  assign bus_oe  = rd_en & ~wr_en;

  mm_ram #(.AW(RAM0_AW), .DW(DATA_W)) u_ram0 (
    .clk(clk), .rst_n(rst_n), .cs(sel[DEV_RAM0]), .we(bus_we), .oe(bus_oe),
    .addr(addr[RAM0_AW-1:0]), .wdata(wdata), .dout(dout_ram0));

  mm_ram #(.AW(RAM1_AW), .DW(DATA_W)) u_ram1 (
    .clk(clk), .rst_n(rst_n), .cs(sel[DEV_RAM1]), .we(bus_we), .oe(bus_oe),
    .addr(addr[RAM1_AW-1:0]), .wdata(wdata), .dout(dout_ram1));

  mm_ioport #(.AW(IO_AW), .DW(DATA_W)) u_io (
    .clk(clk), .rst_n(rst_n), .cs(sel[DEV_IO]), .we(bus_we), .oe(bus_oe),
    .addr(addr[IO_AW-1:0]), .wdata(wdata), .dout(dout_io), .port_o(io_ports));

  // ROM ignores writes: it has no storage path at all
  mm_rom #(.AW(ROM_AW), .DW(DATA_W), .INIT(ROM_INIT)) u_rom (
    .cs(sel[DEV_ROM]), .we(bus_we), .oe(bus_oe),
    .addr(addr[ROM_AW-1:0]), .dout(dout_rom));

  // Deselected or idle devices return zero, so OR-combining is safe
  assign rdata = dout_ram0 | dout_ram1 | dout_io | dout_rom;

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= illegal;
  end
  assign req_err = err_q;

  // R1: at most one device selected
  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
  // R3: unmapped reads return zero
  p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && sel == '0) |-> rdata == '0);
  // R4: ROM read data follows the image
  p_rom_image_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && sel[DEV_ROM]) |-> rdata == ROM_INIT[addr[ROM_AW-1:0]*DATA_W +: DATA_W]);
  // R6: conflict flag is a one-cycle pulse after the request
  p_err_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |=> req_err);
  p_err_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en) |=> !req_err);
  // R7: no read strobe, no read data
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0);
endmodule

// File: tb/mmap_subsys_tb_top.sv
module mmap_subsys_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  rdata;
  logic [63:0] io_ports;
  logic        req_err;

  int n_vec = 0;
  int n_bad = 0;

  mmap_subsys dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
    .io_ports(io_ports), .req_err(req_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [7:0]  exp_rd;
    logic        exp_err;
    logic [63:0] exp_io;
  } item_t;

  item_t q_item [$];
  string q_req  [$];
  event  sample_ev;

  // Independent model of the memory map
  logic [7:0] m_ram0 [64];
  logic [7:0] m_ram1 [32];
  logic [7:0] m_io   [8];
  logic       prev_illegal = 1'b0;

  function automatic logic [7:0] rom_b(int i);
    return 8'((i * 29 + 60) & 255);
  endfunction

  function automatic logic [7:0] model_read(int a);
    if (a < 64)                 return m_ram0[a];
    else if (a < 96)            return m_ram1[a - 64];
    else if (a >= 208 && a < 216) return m_io[a - 208];
    else if (a >= 224)          return rom_b(a - 224);
    else                        return 8'h00;
  endfunction

  function automatic logic [63:0] model_io();
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[k*8 +: 8] = m_io[k];
    return v;
  endfunction

  task automatic model_write(int a, logic [7:0] d);
    if (a < 64)                   m_ram0[a] = d;
    else if (a < 96)              m_ram1[a - 64] = d;
    else if (a >= 208 && a < 216) m_io[a - 208] = d;
  endtask

  // Driver: push expectation, drive, then trigger the monitor mid-cycle
  task automatic do_op(input logic w, input logic r, input int a,
                       input logic [7:0] d, input string req);
    item_t it;
    it.exp_rd  = (r && !w) ? model_read(a) : 8'h00;
    it.exp_err = prev_illegal;
    it.exp_io  = model_io();
    q_item.push_back(it);
    q_req.push_back(req);
    @(negedge clk);
    addr  = 8'(a);
    wdata = d;
    wr_en = w;
    rd_en = r;
    #(CLK_PERIOD/4);
    -> sample_ev;
    if (w && !r) model_write(a, d);
    prev_illegal = w && r;
  endtask

  // Monitor: pop and compare
  always @(sample_ev) begin
    item_t it;
    string req;
    it  = q_item.pop_front();
    req = q_req.pop_front();
    n_vec++;
    if (rdata !== it.exp_rd || req_err !== it.exp_err || io_ports !== it.exp_io) begin
      n_bad++;
      if (rdata !== it.exp_rd)
        $display("FAIL %s addr=%02h rdata actual=%02h expected=%02h", req, addr, rdata, it.exp_rd);
      if (req_err !== it.exp_err)
        $display("FAIL %s req_err actual=%0b expected=%0b", req, req_err, it.exp_err);
      if (io_ports !== it.exp_io)
        $display("FAIL %s io_ports actual=%016h expected=%016h", req, io_ports, it.exp_io);
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) m_ram0[i] = 8'h00;
    for (int i = 0; i < 32; i++) m_ram1[i] = 8'h00;
    for (int i = 0; i < 8; i++)  m_io[i]   = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset contents
    do_op(0, 1, 8'h00, 8'h00, "R8");
    do_op(0, 1, 8'h3F, 8'h00, "R8");
    do_op(0, 1, 8'h5F, 8'h00, "R8");
    do_op(0, 1, 8'hD3, 8'h00, "R8");

    // R2: RAM writes and same-cycle read back at window edges
    do_op(1, 0, 8'h00, 8'hA5, "R2");
    do_op(1, 0, 8'h3F, 8'h5A, "R2");
    do_op(1, 0, 8'h40, 8'h11, "R2");
    do_op(1, 0, 8'h5F, 8'h22, "R2");
    do_op(0, 1, 8'h00, 8'h00, "R2");
    do_op(0, 1, 8'h3F, 8'h00, "R2");
    do_op(0, 1, 8'h40, 8'h00, "R2");
    do_op(0, 1, 8'h5F, 8'h00, "R2");
    for (int i = 0; i < 8; i++) do_op(1, 0, 16 + i, 8'(i * 13 + 7), "R2");
    for (int i = 0; i < 8; i++) do_op(0, 1, 16 + i, 8'h00, "R2");

    // R3: writes to unmapped gaps are lost, reads give zero
    do_op(1, 0, 8'h60, 8'hFF, "R3");
    do_op(1, 0, 8'hCF, 8'hEE, "R3");
    do_op(1, 0, 8'hD8, 8'hDD, "R3");
    do_op(0, 1, 8'h60, 8'h00, "R3");
    do_op(0, 1, 8'hCF, 8'h00, "R3");
    do_op(0, 1, 8'hD8, 8'h00, "R3");
    do_op(0, 1, 8'hDF, 8'h00, "R3");
    do_op(0, 1, 8'h20, 8'h00, "R3");

    // R5: port bank
    for (int k = 0; k < 8; k++) do_op(1, 0, 208 + k, 8'(k * 17 + 1), "R5");
    for (int k = 0; k < 8; k++) do_op(0, 1, 208 + k, 8'h00, "R5");
    do_op(1, 0, 8'hD4, 8'hC3, "R5");
    do_op(0, 0, 8'h00, 8'h00, "R5");

    // R4: ROM contents and write immunity
    do_op(0, 1, 8'hE0, 8'h00, "R4");
    do_op(0, 1, 8'hFF, 8'h00, "R4");
    do_op(1, 0, 8'hE3, 8'h00, "R4");
    do_op(0, 1, 8'hE3, 8'h00, "R4");

    // R6: conflicting strobes
    do_op(1, 1, 8'h00, 8'h77, "R6");
    do_op(0, 1, 8'h00, 8'h00, "R6");
    do_op(0, 0, 8'h00, 8'h00, "R6");
    do_op(1, 1, 8'hD1, 8'h99, "R6");
    do_op(1, 1, 8'hD1, 8'h98, "R6");
    do_op(0, 1, 8'hD1, 8'h00, "R6");

    // R7: no read strobe gives zero everywhere
    do_op(0, 0, 8'h00, 8'h00, "R7");
    do_op(0, 0, 8'hD0, 8'h00, "R7");
    do_op(0, 0, 8'hE5, 8'h00, "R7");

    // R1: full sweep of the address space
    for (int a = 0; a < 256; a++) do_op(0, 1, a, 8'h00, "R1");

    @(negedge clk);
    rd_en = 1'b0;
    wr_en = 1'b0;
    #(CLK_PERIOD);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule